// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Core

This block is a small non-pipelined processor for a 16-bit instruction set with eight general registers. Each instruction walks through a short series of steps (fetch, register read, ALU, memory access, register write), and every step takes one clock. There is a single adder/logic unit. It is shared between the datapath work and the computation of the next program counter. As a result, the default build spends a separate final step on the PC update for every instruction except jalr.

The core talks to one synchronous, word-addressed memory port that carries both instruction fetches and data accesses. Read data comes back in the cycle after the address is presented. A strobe marks the fetch step, so the memory side can tell code traffic from data traffic. A halted flag and a combinational register read port support debug. A build parameter selects an overlap mode. In that mode the PC update is folded into the next-to-last step whenever that step leaves the ALU idle.

Top module: `mc16_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the core presents a fetch (`ifetch`=1) at address 0 and `halted` is 0.
- R2: An instruction word carries the opcode in bits 15..13, register A in 12..10 and register B in 9..7. R-type carries register C in 6..4. I-type carries a 7-bit two's-complement immediate in 6..0. The opcodes are add=000, nand=001, lw=010, sw=011, beq=100, jalr=101, halt=110, and 111 is unused.
- R3: add writes rA+rB into rC, and nand writes ~(rA & rB) into rC.
- R4: lw loads mem[rB+sext(imm)] into rA. sw stores rA to mem[rB+sext(imm)]. Negative offsets work.
- R5: beq moves the PC to PC+1+sext(imm) when rA equals rB, and to PC+1 otherwise.
- R6: jalr writes PC+1 into rA and continues at the address held in rB, using the value of rB from before the write.
- R7: Register 0 reads as zero on every path, and writes to it are dropped.
- R8: After a halt instruction, `halted` rises and stays high until reset, and no further fetch or memory write occurs.
- R9: With OVERLAP=0 the cycles per instruction are add/nand 5, beq 4, jalr 2, lw 6, sw 5, and the unused opcode 3.
- R10: With OVERLAP=1 the cycles per instruction are add/nand 4, beq 4, jalr 2, lw 5, sw 4, and the unused opcode 2.
- R11: The unused opcode 111 changes no register or memory and only advances the PC by one.
- R12: `ifetch` is high for exactly one cycle per instruction, and `mem_we` is never high during a fetch.
- R13: `dbg_data` shows the register selected by `dbg_sel`, with register 0 shown as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Word address for fetch or data access |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Store strobe |
| ifetch | output | 1 | High during the instruction-fetch step |
| mem_rdata | input | 16 | Read data, valid the cycle after the address |
| halted | output | 1 | Sticky halt flag |
| dbg_sel | input | 3 | Debug register select |
| dbg_data | output | 16 | Debug register value |

## Verification
The bench builds two copies of the core side by side, one with OVERLAP=0 and one with OVERLAP=1, and each copy has its own memory. Both run the same program. That program covers every opcode: a taken and a not-taken branch, a skipped store, a negative load offset, a write to register 0, a call and a return. The two builds therefore put the step counts of both modes, the expected fetch address sequence and the final register and memory state under test in one run.

// File: rtl/mc16_core.sv
module mc16_core #(
  parameter bit OVERLAP = 1'b0,
  parameter int W = 16,
  parameter int NREG = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  output logic         ifetch,
  input  logic [W-1:0] mem_rdata,
  output logic         halted,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [W-1:0] dbg_data
);
  localparam int RW = $clog2(NREG);
  localparam logic [2:0] OP_ADD = 3'b000, OP_NAND = 3'b001, OP_LW = 3'b010, OP_SW = 3'b011,
                         OP_BEQ = 3'b100, OP_JALR = 3'b101, OP_HALT = 3'b110;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_EXE, S_MEM, S_WB, S_PC, S_HALT} step_t;
  step_t state;

  logic [W-1:0] pc, ir, a_q, b_q, alu_q;
  logic         eq_q;
  logic [W-1:0] rf [NREG];

  logic [W-1:0] iw;
  assign iw = (state == S_DEC) ? mem_rdata : ir;

  logic [2:0]    op;
  logic [RW-1:0] ra, rb, rc;
  logic [W-1:0]  simm;
  logic          unused_bits;
  assign op   = iw[15:13];
  assign ra   = iw[12:10];
  assign rb   = iw[9:7];
  assign rc   = iw[6:4];
  assign simm = {{(W-7){iw[6]}}, iw[6:0]};
  assign unused_bits = ^iw[3:0];

  function automatic logic [W-1:0] rd(input logic [RW-1:0] i);
    return (i == '0) ? '0 : rf[i];
  endfunction

  logic [W-1:0] alu_x, alu_y, alu_res;
  logic         alu_cin, alu_nand;
  always_comb begin
    alu_x = pc;
    alu_y = (op == OP_BEQ && eq_q) ? simm : '0;
    alu_cin = 1'b1;
    alu_nand = 1'b0;
    if (state == S_EXE) begin
      alu_cin = 1'b0;
      if (op == OP_LW || op == OP_SW) begin
        alu_x = b_q;
        alu_y = simm;
      end else begin
        alu_x = a_q;
        alu_y = b_q;
        alu_nand = (op == OP_NAND);
      end
    end
  end
  assign alu_res = alu_nand ? ~(alu_x & alu_y) : alu_x + alu_y + {{(W-1){1'b0}}, alu_cin};

  assign mem_addr  = (state == S_MEM) ? alu_q : pc;
  assign mem_wdata = a_q;
  assign mem_we    = (state == S_MEM) && (op == OP_SW);
  assign ifetch    = (state == S_FETCH);
  assign halted    = (state == S_HALT);
  assign dbg_data  = rd(dbg_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc <= '0;
      ir <= '0;
      a_q <= '0;
      b_q <= '0;
      alu_q <= '0;
      eq_q <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (state)
        S_FETCH: state <= S_DEC;
        S_DEC: begin
          ir  <= mem_rdata;
          a_q <= rd(ra);
          b_q <= rd(rb);
          case (op)
            OP_JALR: begin
              if (ra != '0) rf[ra] <= alu_res;
              pc <= rd(rb);
              state <= S_FETCH;
            end
            OP_HALT: state <= S_HALT;
            3'b111: begin
              if (OVERLAP) begin
                pc <= alu_res;
                state <= S_FETCH;
              end else state <= S_PC;
            end
            default: state <= S_EXE;
          endcase
        end
        S_EXE: begin
          alu_q <= alu_res;
          eq_q  <= (a_q == b_q);
          case (op)
            OP_LW, OP_SW: state <= S_MEM;
            OP_BEQ:       state <= S_PC;
            default:      state <= S_WB;
          endcase
        end
        S_MEM: begin
          if (op == OP_LW) state <= S_WB;
          else if (OVERLAP) begin
            pc <= alu_res;
            state <= S_FETCH;
          end else state <= S_PC;
        end
        S_WB: begin
          if (op == OP_LW) begin
            if (ra != '0) rf[ra] <= mem_rdata;
          end else if (rc != '0) rf[rc] <= alu_q;
          if (OVERLAP) begin
            pc <= alu_res;
            state <= S_FETCH;
          end else state <= S_PC;
        end
        S_PC: begin
          pc <= alu_res;
          state <= S_FETCH;
        end
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

module mc16_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ifetch,
  input logic        mem_we,
  input logic        halted,
  input logic [15:0] mem_addr
);
  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted);
  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) halted |-> (!ifetch && !mem_we));
  // R8
  halt_addr_chk: assert property (@(posedge clk) disable iff (!rst_n) halted |=> $stable(mem_addr));
  // R12
  fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n) ifetch |=> !ifetch);
  // R12
  no_store_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> !ifetch);
endmodule

bind mc16_core mc16_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ifetch(ifetch), .mem_we(mem_we),
  .halted(halted), .mem_addr(mem_addr)
);

// File: tb/test_mc16_core.sv
`timescale 1ns/1ps
module tb_mem (
  input  logic        clk,
  input  logic [15:0] addr,
  input  logic [15:0] wdata,
  input  logic        we,
  output logic [15:0] rdata
);
  logic [15:0] mem [64];
  always_ff @(posedge clk) begin
    rdata <= mem[addr[5:0]];
    if (we) mem[addr[5:0]] <= wdata;
  end
endmodule

module test_mc16_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] dbg_sel = '0;
  always #2 clk = ~clk;

  logic [15:0] a0, wd0, rdat0, dd0, a1, wd1, rdat1, dd1;
  logic we0, f0, h0, we1, f1, h1;

  mc16_core #(.OVERLAP(1'b0)) i_mc16_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(a0), .mem_wdata(wd0), .mem_we(we0), .ifetch(f0),
    .mem_rdata(rdat0), .halted(h0), .dbg_sel(dbg_sel), .dbg_data(dd0));
  tb_mem m0 (.clk(clk), .addr(a0), .wdata(wd0), .we(we0), .rdata(rdat0));

  mc16_core #(.OVERLAP(1'b1)) i_mc16_core_ovl (
    .clk(clk), .rst_n(rst_n), .mem_addr(a1), .mem_wdata(wd1), .mem_we(we1), .ifetch(f1),
    .mem_rdata(rdat1), .halted(h1), .dbg_sel(dbg_sel), .dbg_data(dd1));
  tb_mem m1 (.clk(clk), .addr(a1), .wdata(wd1), .we(we1), .rdata(rdat1));

  int ntests = 0, nfail = 0;
  int pcq0[$], pcq1[$], cq0[$], cq1[$];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [2:0] op, input logic [2:0] a,
                                      input logic [2:0] b, input logic [6:0] lo);
    return {op, a, b, lo};
  endfunction

  function automatic int cyc(input logic [2:0] op, input bit ovl);
    case (op)
      3'b000, 3'b001: return ovl ? 4 : 5;
      3'b100:         return 4;
      3'b101:         return 2;
      3'b010:         return ovl ? 5 : 6;
      3'b011:         return ovl ? 4 : 5;
      default:        return ovl ? 2 : 3;
    endcase
  endfunction

  task automatic expect_step(input int pc, input logic [2:0] op);
    pcq0.push_back(pc);
    pcq1.push_back(pc);
    cq0.push_back(cyc(op, 1'b0));
    cq1.push_back(cyc(op, 1'b1));
  endtask

  int cnt0 = 0, cnt1 = 0;
  bit seen0 = 0, seen1 = 0;
  // R9 / R5 / R6: monitor for the base build
  always @(negedge clk) if (rst_n && !h0) begin
    cnt0++;
    if (f0) begin
      if (seen0) chk("R9 cycles", 16'(cnt0), (cq0.size() > 0) ? 16'(cq0.pop_front()) : 16'hFFFF);
      chk("R5/R6 fetch pc", a0, (pcq0.size() > 0) ? 16'(pcq0.pop_front()) : 16'hFFFF);
      seen0 = 1;
      cnt0 = 0;
    end
  end
  // R10 / R5 / R6: monitor for the overlap build
  always @(negedge clk) if (rst_n && !h1) begin
    cnt1++;
    if (f1) begin
      if (seen1) chk("R10 cycles", 16'(cnt1), (cq1.size() > 0) ? 16'(cq1.pop_front()) : 16'hFFFF);
      chk("R5/R6 fetch pc ovl", a1, (pcq1.size() > 0) ? 16'(pcq1.pop_front()) : 16'hFFFF);
      seen1 = 1;
      cnt1 = 0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    ntests++;
    nfail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  logic [15:0] prog [18];
  logic [15:0] exp_r [8];
  initial begin
    prog[0]  = enc(3'b010, 3'd1, 3'd0, 7'd40);
    prog[1]  = enc(3'b010, 3'd2, 3'd0, 7'd41);
    prog[2]  = enc(3'b000, 3'd1, 3'd2, 7'h30);
    prog[3]  = enc(3'b001, 3'd1, 3'd2, 7'h40);
    prog[4]  = enc(3'b011, 3'd3, 3'd0, 7'd42);
    prog[5]  = enc(3'b100, 3'd1, 3'd1, 7'd1);
    prog[6]  = enc(3'b011, 3'd1, 3'd0, 7'd44);
    prog[7]  = enc(3'b100, 3'd1, 3'd2, 7'd5);
    prog[8]  = enc(3'b111, 3'd0, 3'd0, 7'd0);
    prog[9]  = enc(3'b010, 3'd7, 3'd0, 7'd43);
    prog[10] = enc(3'b101, 3'd6, 3'd7, 7'd0);
    prog[11] = enc(3'b110, 3'd0, 3'd0, 7'd0);
    prog[12] = 16'h0000;
    prog[13] = 16'h0000;
    prog[14] = enc(3'b000, 3'd1, 3'd1, 7'h00);
    prog[15] = enc(3'b000, 3'd0, 3'd2, 7'h50);
    prog[16] = enc(3'b010, 3'd2, 3'd1, 7'h7F);
    prog[17] = enc(3'b101, 3'd0, 3'd6, 7'd0);
    for (int i = 0; i < 64; i++) begin
      m0.mem[i] = (i < 18) ? prog[i] : 16'h0000;
      m1.mem[i] = (i < 18) ? prog[i] : 16'h0000;
    end
    m0.mem[40] = 16'h0030; m1.mem[40] = 16'h0030;
    m0.mem[41] = 16'h1234; m1.mem[41] = 16'h1234;
    m0.mem[43] = 16'd14;   m1.mem[43] = 16'd14;
    m0.mem[47] = 16'hBEEF; m1.mem[47] = 16'hBEEF;

    expect_step(0, 3'b010);  expect_step(1, 3'b010);  expect_step(2, 3'b000);
    expect_step(3, 3'b001);  expect_step(4, 3'b011);  expect_step(5, 3'b100);
    expect_step(7, 3'b100);  expect_step(8, 3'b111);  expect_step(9, 3'b010);
    expect_step(10, 3'b101); expect_step(14, 3'b000); expect_step(15, 3'b000);
    expect_step(16, 3'b010); expect_step(17, 3'b101);
    pcq0.push_back(11);
    pcq1.push_back(11);

    repeat (3) @(negedge clk);
    // R1
    chk("R1 ifetch in reset", {15'b0, f0}, 16'd1);
    chk("R1 addr in reset", a0, 16'd0);
    chk("R1 halted in reset", {15'b0, h0}, 16'd0);
    chk("R1 ifetch in reset ovl", {15'b0, f1}, 16'd1);
    chk("R1 addr in reset ovl", a1, 16'd0);
    chk("R1 halted in reset ovl", {15'b0, h1}, 16'd0);
    rst_n = 1'b1;

    while (!(h0 && h1)) @(negedge clk);
    repeat (3) @(negedge clk);
    // R8
    chk("R8 halted", {15'b0, h0}, 16'd1);
    chk("R8 halted ovl", {15'b0, h1}, 16'd1);
    chk("R8 no further fetch", {15'b0, f0 | f1}, 16'd0);
    chk("R9 all steps seen", 16'(cq0.size() + pcq0.size()), 16'd0);
    chk("R10 all steps seen", 16'(cq1.size() + pcq1.size()), 16'd0);

    // R3 R4 R6 R7 R11 R13: final register state
    exp_r[0] = 16'h0000; exp_r[1] = 16'h0030; exp_r[2] = 16'hBEEF; exp_r[3] = 16'h1264;
    exp_r[4] = 16'hFFCF; exp_r[5] = 16'h1234; exp_r[6] = 16'd11;   exp_r[7] = 16'd14;
    for (int r = 0; r < 8; r++) begin
      dbg_sel = 3'(r);
      #1;
      chk($sformatf("R13 r%0d (R3/R4/R6/R7)", r), dd0, exp_r[r]);
      chk($sformatf("R13 r%0d ovl (R3/R4/R6/R7)", r), dd1, exp_r[r]);
    end
    // R4: store of rA, R5: taken branch skipped the store, R11: no-op left memory alone
    chk("R4 stored word", m0.mem[42], 16'h1264);
    chk("R4 stored word ovl", m1.mem[42], 16'h1264);
    chk("R5 skipped store", m0.mem[44], 16'h0000);
    chk("R5 skipped store ovl", m1.mem[44], 16'h0000);
    chk("R11 program intact", m0.mem[8], prog[8]);
    chk("R2 program intact ovl", m1.mem[0], prog[0]);
    // R12 is watched continuously by the bound checker
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule